// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block is the digital back end of a small flash analog-to-digital converter. A bank of comparators gives a thermometer word: one bit per reference threshold, set when the analog input lies below that threshold. On each rising edge of the convert clock the block captures that word. It reduces the word to a binary count of the set bits and applies an output format. The formatted code goes into an output register, which holds it until the next edge.

Two active-low static pins choose the format. One inverts the most significant code bit, which turns straight binary into offset two's complement. The other inverts all the lower bits together. With both pins high the code is plain binary. It rises from all zeros at the top of the reference range to all ones at the bottom.

The block has two register stages. A word sampled at one convert edge appears at the outputs after the following edge. The output therefore shows the previous sample while the current one is being taken.

Top module: `fadc_therm_encoder`

## Requirements
- R1: With both format pins high, code_o equals the number of set bits in the captured thermometer word, as unsigned binary with bit 3 the most significant.
- R2: A word present on therm_i at rising edge k is reflected on code_o after rising edge k+1. code_o holds its value between rising edges.
- R3: An all-zero word gives 0000 and an all-ones word gives 1111 with both pins high. Holding either extreme for many cycles never wraps the code.
- R4: While msb_inv_n is 0, code_o[3] is the inverse of the binary count's top bit. The lower bits are unaffected by this pin.
- R5: While lsb_inv_n is 0, code_o[2:0] is the inverse of the binary count's lower three bits. code_o[3] is unaffected by this pin.
- R6: A word with bubbles (non-contiguous set bits) still gives the count of its set bits, never a code set by the highest set bit alone.
- R7: A change on msb_inv_n or lsb_inv_n takes effect on code_o after the next rising edge, without waiting for a new sample.
- R8: A rising edge with rst_n low drives code_o to 0000 and clears the sample stage. The first edge after reset then presents the formatted code of a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_conv | input | 1 | Convert clock; rising edge samples and updates |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_i | input | 15 | Comparator thermometer word, bit k for threshold k |
| msb_inv_n | input | 1 | Active-low inversion of the code MSB |
| lsb_inv_n | input | 1 | Active-low inversion of the three code LSBs |
| code_o | output | 4 | Registered formatted output code |

## Verification
The assertions assume that the format pins and therm_i are stable at each convert edge. They also assume that the sample and output stages have been refilled by at least two or three edges since reset before any sampled word is related to the output. The checker enforces that second point with its own small fill counter.

The bench drives every input half a period away from the rising edge, so each input is a settled level when it is sampled. Random words mix clean thermometer patterns with patterns that have one bit flipped. Directed runs cover the two extremes, all four pin combinations, and a reset applied in the middle of a run.

// File: rtl/fadc_pkg.sv
package fadc_pkg;
    localparam int unsigned FADC_NUM_CMP = 15;
    localparam int unsigned FADC_CODE_W  = 4;
endpackage

// File: rtl/fadc_sample_stage.sv
module fadc_sample_stage #(
    parameter int unsigned NUM_CMP = fadc_pkg::FADC_NUM_CMP
) (
    input  logic               clk_conv,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] therm_i,
    output logic [NUM_CMP-1:0] sample_q
);
    always_ff @(posedge clk_conv) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else begin
            sample_q <= therm_i;
        end
    end
endmodule

// File: rtl/fadc_ones_count.sv
module fadc_ones_count #(
    parameter int unsigned NUM_CMP = fadc_pkg::FADC_NUM_CMP,
    parameter int unsigned CODE_W  = fadc_pkg::FADC_CODE_W
) (
    input  logic [NUM_CMP-1:0] word_i,
    output logic [CODE_W-1:0]  count_o
);
    localparam int unsigned SUM_W    = $clog2(NUM_CMP + 1) + 1;
    localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

    logic [SUM_W-1:0] sum;

    // Counting set bits keeps a single bubble to an error of one code.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_CMP; i++) begin
            sum = sum + {{(SUM_W-1){1'b0}}, word_i[i]};
        end
        if (sum > SUM_W'(MAX_CODE)) begin
            count_o = CODE_W'(MAX_CODE);
        end else begin
            count_o = sum[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/fadc_code_format.sv
module fadc_code_format #(
    parameter int unsigned CODE_W = fadc_pkg::FADC_CODE_W
) (
    input  logic [CODE_W-1:0] count_i,
    input  logic              msb_inv_n,
    input  logic              lsb_inv_n,
    output logic [CODE_W-1:0] code_o
);
    assign code_o[CODE_W-1] = count_i[CODE_W-1] ^ ~msb_inv_n;

    for (genvar b = 0; b < CODE_W - 1; b++) begin : g_low
        assign code_o[b] = count_i[b] ^ ~lsb_inv_n;
    end
endmodule

// File: rtl/fadc_therm_encoder.sv
module fadc_therm_encoder #(
    parameter int unsigned NUM_CMP = fadc_pkg::FADC_NUM_CMP,
    parameter int unsigned CODE_W  = fadc_pkg::FADC_CODE_W
) (
    input  logic               clk_conv,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] therm_i,
    input  logic               msb_inv_n,
    input  logic               lsb_inv_n,
    output logic [CODE_W-1:0]  code_o
);
    logic [NUM_CMP-1:0] sample_q;
    logic [CODE_W-1:0]  count_w;
    logic [CODE_W-1:0]  fmt_w;

    fadc_sample_stage #(.NUM_CMP(NUM_CMP)) u_sample (
        .clk_conv (clk_conv),
        .rst_n    (rst_n),
        .therm_i  (therm_i),
        .sample_q (sample_q)
    );

    fadc_ones_count #(.NUM_CMP(NUM_CMP), .CODE_W(CODE_W)) u_count (
        .word_i  (sample_q),
        .count_o (count_w)
    );

    fadc_code_format #(.CODE_W(CODE_W)) u_format (
        .count_i   (count_w),
        .msb_inv_n (msb_inv_n),
        .lsb_inv_n (lsb_inv_n),
        .code_o    (fmt_w)
    );

    always_ff @(posedge clk_conv) begin
        if (!rst_n) begin
            code_o <= '0;
        end else begin
            code_o <= fmt_w;
        end
    end
endmodule

// File: rtl/fadc_encoder_chk.sv
module fadc_encoder_chk #(
    parameter int unsigned NUM_CMP = fadc_pkg::FADC_NUM_CMP,
    parameter int unsigned CODE_W  = fadc_pkg::FADC_CODE_W
) (
    input logic               clk_conv,
    input logic               rst_n,
    input logic [NUM_CMP-1:0] therm_i,
    input logic               msb_inv_n,
    input logic               lsb_inv_n,
    input logic [CODE_W-1:0]  code_o
);
    logic [1:0] fill_q;

    always_ff @(posedge clk_conv) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != 2'd3) begin
            fill_q <= fill_q + 2'd1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_conv) disable iff (!rst_n)
        $rose(rst_n) |-> code_o == '0); // R8

    AST_ZERO_WORD: assert property (@(posedge clk_conv) disable iff (!rst_n)
        (fill_q >= 2'd2 && $past(therm_i, 2) == '0)
        |-> code_o == {~$past(msb_inv_n), {(CODE_W-1){~$past(lsb_inv_n)}}}); // R3

    AST_FULL_WORD: assert property (@(posedge clk_conv) disable iff (!rst_n)
        (fill_q >= 2'd2 && $past(therm_i, 2) == '1)
        |-> code_o == {$past(msb_inv_n), {(CODE_W-1){$past(lsb_inv_n)}}}); // R4

    AST_HOLD_STEADY: assert property (@(posedge clk_conv) disable iff (!rst_n)
        (fill_q == 2'd3 && $past(therm_i, 2) == $past(therm_i, 3)
         && $past(msb_inv_n) == $past(msb_inv_n, 2)
         && $past(lsb_inv_n) == $past(lsb_inv_n, 2))
        |-> $stable(code_o)); // R2
endmodule

bind fadc_therm_encoder fadc_encoder_chk #(.NUM_CMP(NUM_CMP), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/fadc_therm_encoder_tb.sv
module fadc_therm_encoder_tb;
    localparam int N      = 15;
    localparam int W      = 4;
    localparam int PERIOD = 10;

    logic         clk_conv = 1'b0;
    logic         rst_n    = 1'b0;
    logic [N-1:0] therm_i  = '0;
    logic         msb_inv_n = 1'b1;
    logic         lsb_inv_n = 1'b1;
    logic [W-1:0] code_o;

    int n_run  = 0;
    int n_fail = 0;
    logic [N-1:0] m_samp = '0;
    logic [W-1:0] m_code = '0;

    fadc_therm_encoder u_dut (
        .clk_conv  (clk_conv),
        .rst_n     (rst_n),
        .therm_i   (therm_i),
        .msb_inv_n (msb_inv_n),
        .lsb_inv_n (lsb_inv_n),
        .code_o    (code_o)
    );

    always #(PERIOD/2) clk_conv = ~clk_conv;

    function automatic logic [W-1:0] ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        if (c > 15) c = 15;
        return W'(c);
    endfunction

    function automatic logic [W-1:0] fmt(input logic [W-1:0] c, input logic m, input logic l);
        return {c[3] ^ ~m, c[2:0] ^ {3{~l}}};
    endfunction

    function automatic logic [N-1:0] therm_of(input int n);
        return N'((32'd1 << n) - 1);
    endfunction

    task automatic step(input logic [N-1:0] t, input logic m, input logic l,
                        input logic r, input string tag);
        logic [W-1:0] nc;
        logic [N-1:0] ns;
        therm_i = t; msb_inv_n = m; lsb_inv_n = l; rst_n = r;
        if (!r) begin nc = '0; ns = '0; end
        else begin nc = fmt(ones(m_samp), m, l); ns = t; end
        @(negedge clk_conv);
        m_samp = ns; m_code = nc;
        n_run++;
        if (code_o !== m_code) begin
            n_fail++;
            $display("FAIL %s: code_o=%b expected %b", tag, code_o, m_code);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] rv;
        void'($urandom(32'h5A17));
        @(negedge clk_conv);
        // R8: reset, with pins both high and both low
        step('1, 1'b1, 1'b1, 1'b0, "R8 reset");
        step('1, 1'b0, 1'b0, 1'b0, "R8 reset pins low");
        step('1, 1'b0, 1'b0, 1'b1, "R8 first edge after reset");
        step('0, 1'b0, 1'b0, 1'b1, "R8 zero count formatted");
        // R1 R2: sweep of clean thermometer words
        for (int n = 0; n <= 15; n++) step(therm_of(n), 1'b1, 1'b1, 1'b1, "R1 sweep");
        for (int n = 15; n >= 0; n--) step(therm_of(n), 1'b1, 1'b1, 1'b1, "R2 latency");
        // R3: extremes held
        for (int k = 0; k < 8; k++) step('1, 1'b1, 1'b1, 1'b1, "R3 full scale");
        for (int k = 0; k < 8; k++) step('0, 1'b1, 1'b1, 1'b1, "R3 zero scale");
        // R4 R5: each pin combination across the sweep
        for (int n = 0; n <= 15; n++) step(therm_of(n), 1'b0, 1'b1, 1'b1, "R4 msb inverted");
        for (int n = 0; n <= 15; n++) step(therm_of(n), 1'b1, 1'b0, 1'b1, "R5 lsbs inverted");
        for (int n = 0; n <= 15; n++) step(therm_of(n), 1'b0, 1'b0, 1'b1, "R5 both inverted");
        // R7: pins toggle while the word stays
        step(therm_of(9), 1'b1, 1'b1, 1'b1, "R7 setup");
        step(therm_of(9), 1'b1, 1'b1, 1'b1, "R7 setup");
        step(therm_of(9), 1'b0, 1'b1, 1'b1, "R7 msb pin change");
        step(therm_of(9), 1'b0, 1'b0, 1'b1, "R7 lsb pin change");
        step(therm_of(9), 1'b1, 1'b1, 1'b1, "R7 pins restored");
        // R6: bubbles
        step(15'b000_0000_0000_0101, 1'b1, 1'b1, 1'b1, "R6 bubble");
        step(15'b100_0000_0000_0001, 1'b1, 1'b1, 1'b1, "R6 stray top bit");
        step(15'b011_1111_1101_1111, 1'b1, 1'b1, 1'b1, "R6 hole");
        step(15'b000_0000_0000_0000, 1'b1, 1'b1, 1'b1, "R6 drain");
        // R8: reset mid-run
        step(therm_of(12), 1'b1, 1'b1, 1'b1, "R8 pre");
        step(therm_of(12), 1'b1, 1'b1, 1'b0, "R8 mid-run reset");
        step(therm_of(5), 1'b1, 1'b1, 1'b1, "R8 release");
        step(therm_of(5), 1'b1, 1'b1, 1'b1, "R8 refill");
        // R1 R6: random mix
        for (int k = 0; k < 3000; k++) begin
            rv = therm_of(int'($urandom % 16));
            if ($urandom % 4 == 0) rv[$urandom % N] ^= 1'b1;
            step(rv, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 200) != 0,
                 "R1 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule